// File: doc/BRIEF.md
# Double-Buffered Backlight PWM Controller

This block produces one pulse-width-modulated output for a display backlight. Software sets it up through a small register window of 32-bit words, using a one-cycle write strobe and a read strobe. The window holds a clock prescaler, a period length and a high-time length.

Those three values are written into staging registers and have no effect on the waveform until software commits them. A commit is a rising edge of a dedicated commit bit. While the output runs, the new values take over at the next period boundary, so no period is ever cut short or stretched. While the output is off, they take over at once.

Every field counts in "value plus one" units. The high-time field is one bit wider than the period field, so the output can be held high through an entire period.

Top module: `blpwm_top`

## Requirements
- R1: After reset every register reads zero, and `pwm_out` is low.
- R2: Registers read back what was written, with every bit outside a field reading zero:
  - offset 0x00 holds the on/off bit in bit 0;
  - offset 0x08 holds the commit bit in bit 0;
  - offset 0x10 holds the 10-bit divide field in bits 25:16;
  - offset 0x14 holds the 12-bit period field in bits 11:0 and the 13-bit high field in bits 28:16.
  - `reg_rdata` is zero whenever `reg_rd` is low.
- R3: Reads from any other offset return zero, and writes to any other offset change no register and do not change the output.
- R4: With divide value D and period value P, one period of the output lasts (D+1)*(P+1) clock cycles and repeats without gaps.
- R5: With a high value H below P, the output is high for the first (H+1)*(D+1) cycles of each period and low for the rest.
- R6: With H greater than or equal to P, the output stays high for the whole period.
- R7: Writes to the divide, period and high fields do not change the waveform until the commit bit goes from 0 to 1. Writing 1 while the bit already holds 1 commits nothing.
- R8: A commit made while the output runs lets the current period finish with the old values. The new values apply from the first cycle of the next period.
- R9: A commit made while the output is off loads the staged values in the same clock edge.
- R10: While the on/off bit is 0 the output is low. In the cycle after the bit is written to 1, a fresh period starts with the output high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for registers and counters |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe; one write per cycle |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, zero when not reading |
| pwm_out | output | 1 | Backlight PWM waveform |

## Verification
The assertions assume the following about the inputs:
- at most one register write happens per cycle;
- a commit write never coincides with a write to the staging fields;
- the staging registers are stable in the cycle a commit is taken, which is what makes a load while the output is off equal the previous cycle's staged value.

The bench issues accesses one per cycle from tasks and never overlaps two writes. It keeps random divide values small, so that whole periods fit in the sampling windows. Its only long-period case is a directed one at the largest divide value.

// File: rtl/blpwm_pkg.sv
// Package: shared constants and the configuration record for the backlight PWM.
// Assumes byte offsets on an 8-bit address and 32-bit register words.
package blpwm_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int DIV_W    = 10;
    localparam int PER_W    = 12;
    localparam int HIGH_W   = 13;
    localparam int DIV_LSB  = 16;
    localparam int PER_LSB  = 0;
    localparam int HIGH_LSB = 16;
    localparam int CMP_W    = (HIGH_W > PER_W) ? HIGH_W : PER_W;

    localparam logic [ADDR_W-1:0] OFS_ONOFF  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_COMMIT = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL0  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CTRL1  = 8'h14;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [PER_W-1:0]  per;
        logic [HIGH_W-1:0] high;
    } pwm_cfg_t;
endpackage

// File: rtl/blpwm_regs.sv
// Module: register window with staging fields, on/off bit and commit bit.
// Produces a one-cycle commit request on a 0-to-1 write of the commit bit.
// Assumes one access per cycle; read data is combinational.
module blpwm_regs
    import blpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              enable,
    output pwm_cfg_t          shadow,
    output logic              commit_req
);
    logic     on_q, commit_q;
    pwm_cfg_t shd_q;
    logic     hit_on, hit_commit, hit_c0, hit_c1, any_hit;
    logic     unused_wdata;

    // Purpose: decode the offset into one hit per register.
    always_comb begin
        hit_on     = (addr == OFS_ONOFF);
        hit_commit = (addr == OFS_COMMIT);
        hit_c0     = (addr == OFS_CTRL0);
        hit_c1     = (addr == OFS_CTRL1);
        any_hit    = hit_on | hit_commit | hit_c0 | hit_c1;
    end

    // Purpose: store written fields; undecoded offsets are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q     <= 1'b0;
            commit_q <= 1'b0;
            shd_q    <= '0;
        end else if (wr_en) begin
            if (hit_on)     on_q       <= wdata[0];
            if (hit_commit) commit_q   <= wdata[0];
            if (hit_c0)     shd_q.div  <= wdata[DIV_LSB +: DIV_W];
            if (hit_c1) begin
                shd_q.per  <= wdata[PER_LSB +: PER_W];
                shd_q.high <= wdata[HIGH_LSB +: HIGH_W];
            end
        end
    end

    // Purpose: rising edge of the commit bit as seen by the write.
    assign commit_req = wr_en && hit_commit && wdata[0] && !commit_q;

    // Purpose: assemble read data with unused bits at zero.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                OFS_ONOFF:  rdata[0] = on_q;
                OFS_COMMIT: rdata[0] = commit_q;
                OFS_CTRL0:  rdata[DIV_LSB +: DIV_W] = shd_q.div;
                OFS_CTRL1: begin
                    rdata[PER_LSB +: PER_W]   = shd_q.per;
                    rdata[HIGH_LSB +: HIGH_W] = shd_q.high;
                end
                default:    rdata = '0;
            endcase
        end
    end

    assign enable       = on_q;
    assign shadow       = shd_q;
    assign unused_wdata = &wdata;

    assert_undef_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !any_hit) |=> $stable({on_q, commit_q, shd_q}));

    assert_commit_sets_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |=> commit_q);
endmodule

// File: rtl/blpwm_active.sv
// Module: active configuration set and pending-commit flag.
// Loads the staged values at a period wrap, or at once while the output is off.
// Assumes the staging registers do not change in the cycle a commit is taken.
module blpwm_active
    import blpwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  pwm_cfg_t shadow,
    input  logic     commit_req,
    input  logic     wrap,
    output pwm_cfg_t act
);
    pwm_cfg_t act_q;
    logic     pend_q;
    logic     load;

    // Purpose: a commit is due now or queued, and the timing allows a swap.
    assign load = (pend_q || commit_req) && (!enable || wrap);

    // Purpose: swap in the staged values and track outstanding commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (load) act_q <= shadow;
            if (load)            pend_q <= 1'b0;
            else if (commit_req) pend_q <= 1'b1;
        end
    end

    assign act = act_q;

    assert_hold_mid_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !wrap) |=> $stable(act_q));

    assert_disabled_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && commit_req) |=> (act_q == $past(shadow)));
endmodule

// File: rtl/blpwm_prescale.sv
// Module: clock prescaler producing one tick every (div_lim + 1) cycles.
// Held at zero while the output is off; restarts from zero when enabled.
module blpwm_prescale
    import blpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_lim,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q == div_lim);

    // Purpose: count cycles up to the divide limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) cnt_q <= '0;
        else if (tick)         cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assert_pre_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= div_lim);
endmodule

// File: rtl/blpwm_frame.sv
// Module: period position counter and output compare.
// Output is high while the position is not past the high limit; a high limit
// at or above the period limit therefore keeps it high all period.
module blpwm_frame
    import blpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic [PER_W-1:0]  per_lim,
    input  logic [HIGH_W-1:0] high_lim,
    output logic              wrap,
    output logic              pwm_out
);
    logic [PER_W-1:0] pos_q;
    logic             in_high;

    assign wrap    = tick && (pos_q == per_lim);
    assign in_high = CMP_W'(pos_q) <= CMP_W'(high_lim);
    assign pwm_out = enable && in_high;

    // Purpose: advance the position once per prescaled tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) pos_q <= '0;
        else if (wrap)         pos_q <= '0;
        else if (tick)         pos_q <= pos_q + 1'b1;
    end

    assert_pos_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= per_lim);

    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pos_q == '0));

    assert_start_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pos_q == '0) |-> pwm_out);

    assert_full_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && CMP_W'(high_lim) >= CMP_W'(per_lim)) |-> pwm_out);
endmodule

// File: rtl/blpwm_top.sv
// Module: top of the double-buffered backlight PWM controller.
// Ties the register window, active set, prescaler and frame counter together.
module blpwm_top
    import blpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pwm_out
);
    logic     enable, commit_req, tick, wrap;
    pwm_cfg_t shadow, act;

    blpwm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
        .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .enable(enable), .shadow(shadow), .commit_req(commit_req)
    );

    blpwm_active u_active (
        .clk(clk), .rst_n(rst_n), .enable(enable), .shadow(shadow),
        .commit_req(commit_req), .wrap(wrap), .act(act)
    );

    blpwm_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_lim(act.div), .tick(tick)
    );

    blpwm_frame u_frame (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .per_lim(act.per), .high_lim(act.high), .wrap(wrap), .pwm_out(pwm_out)
    );
endmodule

// File: tb/tb_blpwm_top.sv
module tb_blpwm_top;
    localparam logic [7:0] A_ON = 8'h00, A_CM = 8'h08, A_C0 = 8'h10, A_C1 = 8'h14;

    logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out;
    int          n_tests = 0, n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    blpwm_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pwm_out(pwm_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic bit exp_pwm(input int t, input int d, input int p, input int h);
        int pos;
        pos = (t % ((d + 1) * (p + 1))) / (d + 1);
        return pos <= h;
    endfunction

    task automatic cfg(input int d, input int p, input int h);
        wr(A_C0, 32'(d) << 16);
        wr(A_C1, (32'(h) << 16) | 32'(p));
    endtask

    task automatic commit();
        wr(A_CM, 32'd1);
        wr(A_CM, 32'd0);
    endtask

    task automatic start(input int d, input int p, input int h);
        wr(A_ON, 32'd0);
        cfg(d, p, h);
        commit();
        wr(A_ON, 32'd1);
    endtask

    // Samples n cycles from a fresh period; after split cycles switches to config 2.
    task automatic measure(input string req, input int n, input int split,
                           input int d1, input int p1, input int h1,
                           input int d2, input int p2, input int h2);
        int bad;
        bit e;
        bad = 0;
        for (int t = 0; t < n; t++) begin
            e = (t < split) ? exp_pwm(t, d1, p1, h1) : exp_pwm(t - split, d2, p2, h2);
            if (pwm_out !== e) bad++;
            @(negedge clk);
        end
        check(req, 32'(bad), 32'd0);
    endtask

    task automatic run(input string req, input int n, input int d, input int p, input int h);
        measure(req, n, n, d, p, h, d, p, h);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, r;
        int highs;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_ON, v); check("R1 onoff", v, 0);
        rd(A_CM, v); check("R1 commit", v, 0);
        rd(A_C0, v); check("R1 ctrl0", v, 0);
        rd(A_C1, v); check("R1 ctrl1", v, 0);
        check("R1 pwm low", 32'(pwm_out), 0);

        // R2: readback of all-ones and random data, unused bits zero
        wr(A_C0, 32'hFFFF_FFFF); rd(A_C0, v); check("R2 ctrl0 ones", v, 32'h03FF_0000);
        wr(A_C1, 32'hFFFF_FFFF); rd(A_C1, v); check("R2 ctrl1 ones", v, 32'h1FFF_0FFF);
        wr(A_ON, 32'hFFFF_FFFE); rd(A_ON, v); check("R2 onoff even", v, 0);
        wr(A_CM, 32'hFFFF_FFFF); rd(A_CM, v); check("R2 commit ones", v, 1);
        wr(A_CM, 32'd0);
        for (int i = 0; i < 6; i++) begin
            r = $urandom();
            wr(A_C0, r); rd(A_C0, v); check("R2 ctrl0 rand", v, r & 32'h03FF_0000);
            r = $urandom();
            wr(A_C1, r); rd(A_C1, v); check("R2 ctrl1 rand", v, r & 32'h1FFF_0FFF);
        end
        reg_addr = A_C1; #1 check("R2 rdata idle zero", reg_rdata, 0);

        // R3: undefined offsets
        wr(A_ON, 32'd0);
        wr(A_C0, 32'h0005_0000); wr(A_C1, 32'h0003_0007);
        foreach (r[i]) if (i < 0) r = 0;
        rd(8'h04, v); check("R3 read 04", v, 0);
        rd(8'h0C, v); check("R3 read 0C", v, 0);
        rd(8'hFC, v); check("R3 read FC", v, 0);
        wr(8'h04, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF);
        rd(A_ON, v); check("R3 onoff kept", v, 0);
        rd(A_CM, v); check("R3 commit kept", v, 0);
        rd(A_C0, v); check("R3 ctrl0 kept", v, 32'h0005_0000);
        rd(A_C1, v); check("R3 ctrl1 kept", v, 32'h0003_0007);
        check("R3 pwm still low", 32'(pwm_out), 0);

        // R4/R5: directed shapes
        start(1, 6, 0);  run("R5 high zero", 28, 1, 6, 0);
        start(2, 5, 3);  run("R5 partial", 36, 2, 5, 3);
        start(0, 0, 0);  run("R4 one-cycle period", 6, 0, 0, 0);
        start(1023, 1, 0); run("R4 max divide", 4096, 1023, 1, 0);

        // R6: high at or above period
        start(0, 9, 15); run("R6 high above", 30, 0, 9, 15);
        start(2, 5, 5);  run("R6 high equal", 36, 2, 5, 5);

        // R8: commit while running waits for the period wrap
        start(1, 9, 3);
        fork
            measure("R8 deferred commit", 40, 20, 1, 9, 3, 0, 4, 1);
            begin
                repeat (2) @(negedge clk);
                cfg(0, 4, 1);
                commit();
            end
        join

        // R9 and R7: commit while off is immediate; no edge means no commit
        wr(A_ON, 32'd0);
        cfg(0, 3, 1);
        wr(A_CM, 32'd1);
        cfg(0, 7, 6);
        wr(A_CM, 32'd1);
        wr(A_ON, 32'd1);
        run("R7 no re-commit", 8, 0, 3, 1);
        wr(A_ON, 32'd0);
        wr(A_CM, 32'd0); wr(A_CM, 32'd1); wr(A_CM, 32'd0);
        wr(A_ON, 32'd1);
        run("R9 immediate load", 16, 0, 7, 6);

        // R7: staged writes while running leave waveform unchanged
        start(0, 5, 2);
        fork
            run("R7 staged only", 30, 0, 5, 2);
            cfg(0, 1, 0);
        join

        // R10: disable holds output low, re-enable starts high
        wr(A_ON, 32'd0);
        highs = 0;
        for (int t = 0; t < 10; t++) begin
            highs += int'(pwm_out);
            @(negedge clk);
        end
        check("R10 low while off", 32'(highs), 0);
        wr(A_ON, 32'd1);
        check("R10 fresh start high", 32'(pwm_out), 1);
        run("R10 fresh period", 12, 0, 5, 2);

        // R4/R5/R6: random configurations
        for (int i = 0; i < 10; i++) begin
            int d, p, h;
            d = $urandom_range(0, 3);
            p = $urandom_range(0, 15);
            h = $urandom_range(0, 20);
            start(d, p, h);
            run("R4 R5 random", 2 * (d + 1) * (p + 1), d, p, h);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule